// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static Memory

This block is a clocked model of a 16-bit asynchronous static memory. It has two chip selects of opposite polarity, an active-low control for each byte lane, an active-low write strobe and an active-low output enable. It decodes these controls into a separate mode for each byte lane: idle, write or read. Writes reach only the lanes whose control is low. Read data goes out on a split data bus, and each lane has its own drive-enable flag, so a surrounding pad ring or a bus model can tri-state each byte on its own.

All control decoding is combinational. Writes commit on the rising clock edge. The output stage is registered: the lane drive enables, the read data and the standby and active flags all reflect the controls that were present at the previous edge. The address port is always 18 bits wide. Only the low `ADDR_W` bits select a word, which keeps the storage small in simulation. Memory contents are undefined until they are written.

Top module: `dsel_sram`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `lane_oe` = 0, `standby` = 1, `active` = 0 and `rdata` = 0, whatever the control inputs are.
- R2: The device is selected only when `sel_n` = 0 and `sel` = 1. With either select inactive, after the edge no lane is driven, nothing is written and `standby` = 1.
- R3: When both bits of `lane_n` are 1, the device is deselected regardless of `wr_n` and `oe_n`: no write, no drive, `standby` = 1.
- R4: When the device is selected, `wr_n` = 0 and `lane_n[i]` = 0, the byte for lane i of `wdata` is stored at the word address on that clock edge.
- R5: A lane whose `lane_n` bit is 1 is neither written nor driven, even while the other lane is active.
- R6: When the device is selected, `wr_n` = 1, `oe_n` = 0 and `lane_n[i]` = 0, then after the edge `lane_oe[i]` = 1 and that byte of `rdata` holds the stored byte.
- R7: When the device is selected, `wr_n` = 1 and `oe_n` = 1, then after the edge `lane_oe` = 0 and `active` = 1.
- R8: During a write `lane_oe` is 0 after the edge, even when `oe_n` = 0.
- R9: After every edge out of reset, `standby` = 1 exactly when the device was deselected (R2 or R3), and `active` is its complement.
- R10: Address bits at or above `ADDR_W` are ignored: two addresses that differ only in those bits reach the same word.
- R11: Lane 0 (`lane_n[0]`, `lane_oe[0]`) covers data bits 7:0 and lane 1 covers bits 15:8. A disabled lane reads as zero on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 18 | Word address; only the low ADDR_W bits are used |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| lane_n | input | 2 | Active-low byte-lane controls, bit 0 = low byte |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, zero in undriven lanes |
| lane_oe | output | 2 | Per-lane drive enable for the data bus |
| standby | output | 1 | Device was deselected at the last edge |
| active | output | 1 | Device was selected at the last edge |

## Verification
The bench builds the block with `ADDR_W` = 4, so the memory has 16 words. For every one of those words it applies all 64 combinations of the six control inputs, and it puts a different pattern into the ignored upper address bits on each step. This makes every mode, every masked write and the address aliasing reachable in about a thousand cycles. A reference array kept in the bench follows every byte write, and a final full read of all words shows that masked lanes held their old contents.

// File: rtl/dsel_sram_pkg.sv
package dsel_sram_pkg;

    localparam int LANES     = 2;
    localparam int FULL_AW   = 18;

    typedef enum logic [1:0] {
        LM_IDLE  = 2'd0,
        LM_WRITE = 2'd1,
        LM_READ  = 2'd2
    } lane_mode_e;

    typedef struct packed {
        logic             sel_n;
        logic             sel;
        logic [LANES-1:0] lane_n;
        logic             wr_n;
        logic             oe_n;
    } ctrl_t;

    function automatic logic chip_on(ctrl_t c);
        return !c.sel_n && c.sel && !(&c.lane_n);
    endfunction

    function automatic lane_mode_e lane_mode(ctrl_t c, int lane);
        if (!chip_on(c) || c.lane_n[lane])
            return LM_IDLE;
        if (!c.wr_n)
            return LM_WRITE;
        if (!c.oe_n)
            return LM_READ;
        return LM_IDLE;
    endfunction

endpackage

// File: rtl/dsel_sram_decode.sv
module dsel_sram_decode
    import dsel_sram_pkg::*;
(
    input  ctrl_t            ctrl,
    output logic [LANES-1:0] wr_en,
    output logic [LANES-1:0] rd_en,
    output logic             deselect
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_mode_e m;
        always_comb begin
            m        = lane_mode(ctrl, g);
            wr_en[g] = (m == LM_WRITE);
            rd_en[g] = (m == LM_READ);
        end
    end

    always_comb deselect = !chip_on(ctrl);

    always_comb begin
        // R8: no lane can be reading and writing in the same cycle
        lane_excl_chk: assert ((wr_en & rd_en) == '0);
    end
endmodule

// File: rtl/dsel_sram_bank.sv
module dsel_sram_bank #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[addr] <= wd;
    end

    always_comb rd = store[addr];
endmodule

// File: rtl/dsel_sram_outreg.sv
module dsel_sram_outreg
    import dsel_sram_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        rd_en,
    input  logic                    deselect,
    input  logic [LANES*LANE_W-1:0] bank_rd,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        lane_oe,
    output logic                    standby,
    output logic                    active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lane_oe <= '0;
            standby <= 1'b1;
            active  <= 1'b0;
        end else begin
            lane_oe <= rd_en;
            standby <= deselect;
            active  <= !deselect;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_data
        always_ff @(posedge clk) begin
            if (rst || !rd_en[g])
                rdata[g*LANE_W +: LANE_W] <= '0;
            else
                rdata[g*LANE_W +: LANE_W] <= bank_rd[g*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/dsel_sram.sv
module dsel_sram
    import dsel_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FULL_AW-1:0] addr,
    input  logic               sel_n,
    input  logic               sel,
    input  logic [LANES-1:0]   lane_n,
    input  logic               wr_n,
    input  logic               oe_n,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [LANES-1:0]   lane_oe,
    output logic               standby,
    output logic               active
);
    ctrl_t              ctrl;
    logic [LANES-1:0]   wr_en;
    logic [LANES-1:0]   rd_en;
    logic               deselect;
    logic [ADDR_W-1:0]  word;
    logic [DATA_W-1:0]  bank_rd;

    always_comb begin
        ctrl.sel_n  = sel_n;
        ctrl.sel    = sel;
        ctrl.lane_n = lane_n;
        ctrl.wr_n   = wr_n;
        ctrl.oe_n   = oe_n;
        word        = addr[ADDR_W-1:0];
    end

    dsel_sram_decode u_dec (
        .ctrl     (ctrl),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .deselect (deselect)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        dsel_sram_bank #(.ADDR_W(ADDR_W), .DATA_W(LANE_W)) u_bank (
            .clk  (clk),
            .we   (wr_en[g]),
            .addr (word),
            .wd   (wdata[g*LANE_W +: LANE_W]),
            .rd   (bank_rd[g*LANE_W +: LANE_W])
        );
    end

    dsel_sram_outreg #(.LANE_W(LANE_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .deselect (deselect),
        .bank_rd  (bank_rd),
        .rdata    (rdata),
        .lane_oe  (lane_oe),
        .standby  (standby),
        .active   (active)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (lane_oe == '0 && standby && !active));

    // R2
    select_off_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_n || !sel) |=> (standby && lane_oe == '0));

    // R3
    both_lanes_off_chk: assert property (@(posedge clk) disable iff (rst)
        (&lane_n) |=> (standby && lane_oe == '0));

    // R8
    write_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && sel && !wr_n) |=> (lane_oe == '0));

    // R6
    low_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && sel && wr_n && !oe_n && !lane_n[0]) |=> lane_oe[0]);

    // R7
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && sel && !(&lane_n) && wr_n && oe_n) |=> (active && lane_oe == '0));
endmodule

// File: tb/dsel_sram_test.sv
`timescale 1ns/1ps
module dsel_sram_test;
    localparam int AW    = 4;
    localparam int WORDS = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] addr = '0;
    logic        sel_n = 1'b0, sel = 1'b1;
    logic [1:0]  lane_n = 2'b00;
    logic        wr_n = 1'b1, oe_n = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  lane_oe;
    logic        standby, active;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] model [WORDS];

    always #2.5 clk = ~clk;

    dsel_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .addr(addr), .sel_n(sel_n), .sel(sel),
        .lane_n(lane_n), .wr_n(wr_n), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .lane_oe(lane_oe), .standby(standby), .active(active)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // apply controls, step one edge, leave outputs to be sampled
    task automatic step(input logic [17:0] a, input logic [5:0] c, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        {sel_n, sel, lane_n, wr_n, oe_n} = c;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", n_tests);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: read controls held during reset
        repeat (3) @(posedge clk);
        #1;
        check("R1 lane_oe", 32'(lane_oe), 0);
        check("R1 standby", 32'(standby), 1);
        check("R1 active",  32'(active), 0);
        check("R1 rdata",   32'(rdata), 0);
        @(negedge clk); rst = 1'b0;

        // fill every word with both lanes: sel_n=0 sel=1 lane_n=00 wr_n=0 oe_n=1
        for (int a = 0; a < WORDS; a++) begin
            logic [15:0] v;
            v = 16'(a * 16'h1111) ^ 16'hA5C3;
            step(18'(a), 6'b010001, v);
            model[a] = v;
        end

        // sweep: every word x every control combination
        for (int a = 0; a < WORDS; a++) begin
            for (int c = 0; c < 64; c++) begin
                logic b_seln, b_sel, b_wr, b_oe, on;
                logic [1:0] b_ln, exp_oe;
                logic [15:0] d, exp_rd, old;
                logic [17:0] fa;
                b_seln = c[5]; b_sel = c[4]; b_ln = c[3:2]; b_wr = c[1]; b_oe = c[0];
                on = (b_seln == 0) && (b_sel == 1) && (b_ln != 2'b11);
                d  = 16'((a * 37 + c * 101 + 90) * 257);
                fa = 18'(a) + (18'(c) << AW);       // R10 upper bits vary
                old = model[a];
                exp_oe = '0;
                exp_rd = '0;
                for (int l = 0; l < 2; l++) begin
                    if (on && !b_ln[l] && b_wr && !b_oe) begin
                        exp_oe[l] = 1'b1;
                        exp_rd[l*8 +: 8] = old[l*8 +: 8];
                    end
                    if (on && !b_ln[l] && !b_wr)
                        model[a][l*8 +: 8] = d[l*8 +: 8];
                end
                step(fa, 6'(c), d);
                if (!b_seln && b_sel)
                    check(b_ln == 2'b11 ? "R3 standby" : "R9 standby", 32'(standby), 32'(!on));
                else
                    check("R2 standby", 32'(standby), 1);
                check("R9 active", 32'(active), 32'(on));
                if (on && !b_wr)
                    check("R8 lane_oe", 32'(lane_oe), 32'(exp_oe));
                else if (on && b_ln != 2'b00)
                    check("R5 lane_oe", 32'(lane_oe), 32'(exp_oe));
                else if (on && b_oe)
                    check("R7 lane_oe", 32'(lane_oe), 32'(exp_oe));
                else
                    check("R6 lane_oe", 32'(lane_oe), 32'(exp_oe));
                check("R11 rdata", 32'(rdata), 32'(exp_rd));
            end
        end

        // readback of all words: masked writes kept the old bytes
        for (int a = 0; a < WORDS; a++) begin
            step(18'(a), 6'b010010, 16'h0);
            check("R4 readback", 32'(rdata), 32'(model[a]));
            check("R6 both lanes", 32'(lane_oe), 3);
        end

        // R10: write through an aliased address, read through the plain one
        step(18'h3_FFF0 | 18'd3, 6'b010001, 16'hBEEF);
        step(18'd3, 6'b010010, 16'h0);
        check("R10 alias", 32'(rdata), 32'hBEEF);

        // R11: upper lane only write then upper-only read
        step(18'd5, 6'b010101, 16'h7E00);
        step(18'd5, 6'b010110, 16'h0);
        check("R11 upper lane", 32'(rdata), {16'h0, 8'h7E, 8'h00});
        check("R11 upper oe",   32'(lane_oe), 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule